// File: doc/BRIEF.md
# Saturating Integrator with Overflow Exceptions

This block sums signed samples into a wide signed accumulator and counts how many samples it has taken. The accumulator and the sample counter each have their own saturation enable. With saturation on, a value that would leave its range is held at the range limit. With saturation off, the value wraps around.

Overflow is first recorded in a hidden pending bit. The overflow flag that the system can see changes only when a capture or read event publishes that pending state. Three events publish it: a hardware capture request, a software capture request, or a read of the current value. A capture copies the accumulator and the count into final registers. A read copies the count into a current-count register.

Exception flags are set by rules that depend on the saturation mode. Any exception drives an error interrupt, but only while the interrupt enable is set. An integrator reset clears the running state. Flags are cleared by writing ones to a clear vector.

Top module: `integ_ovf_top`

## Requirements
- R1: Each cycle with `smp_valid` high and `int_rst` low adds the sign-extended `smp_data` to `acc_val` and adds one to `cnt_val`; both change in the cycle after the strobe.
- R2: An addition that leaves the signed range of `acc_val` wraps modulo 2^ACC_W when `sat_acc_en` is 0. When `sat_acc_en` is 1 it clamps to the largest positive value (positive overflow) or the most negative value (negative overflow).
- R3: An increment past the all-ones value of `cnt_val` wraps to 0 when `sat_cnt_en` is 0. When `sat_cnt_en` is 1 the counter holds at all ones.
- R4: `sum_ovf` and `cnt_ovf` are set only in the cycle after a publish event (`hw_cap`, `sw_cap` or `rd_cur`), and only if the matching overflow happened since the last publish event or integrator reset. An overflow with no publish event leaves the flag unchanged.
- R5: With saturation enabled for a path, that path's exception flag is set in the same cycle as its overflow flag, every time the overflow is published.
- R6: With saturation disabled for a path, a publish that finds a pending overflow sets the exception flag only if the overflow flag was already 1.
- R7: With saturation disabled for a path, a second overflow with no publish event and no integrator reset since the first sets the exception flag and leaves the overflow flag unchanged.
- R8: `hw_cap` or `sw_cap` copies the pre-update `acc_val` and `cnt_val` into `fin_val` and `fin_cnt`. `rd_cur` copies the pre-update `cnt_val` into `cur_cnt` and leaves `fin_val` and `fin_cnt` unchanged.
- R9: `int_rst` clears `acc_val`, `cnt_val` and both pending overflow bits, and ignores a sample in the same cycle. A publish after the reset therefore does not set an overflow flag.
- R10: A 1 in `flag_clr` clears one flag: bit 0 `sum_ovf`, bit 1 `sum_exc`, bit 2 `cnt_ovf`, bit 3 `cnt_exc`. A set in the same cycle takes priority over the clear.
- R11: `err_irq` is high exactly when `err_irq_en` is 1 and `sum_exc` or `cnt_exc` is 1.
- R12: After `rst_n` reset, every output register is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_valid | input | 1 | Sample strobe |
| smp_data | input | SAMPLE_W | Signed sample |
| hw_cap | input | 1 | Hardware capture request |
| sw_cap | input | 1 | Software capture request |
| rd_cur | input | 1 | Read strobe for the current value |
| int_rst | input | 1 | Integrator reset |
| sat_acc_en | input | 1 | Accumulator saturation enable |
| sat_cnt_en | input | 1 | Counter saturation enable |
| err_irq_en | input | 1 | Error interrupt enable |
| flag_clr | input | 4 | Write-one-to-clear vector for the flags |
| acc_val | output | ACC_W | Running accumulator |
| cnt_val | output | CNT_W | Running sample count |
| fin_val | output | ACC_W | Captured accumulator |
| fin_cnt | output | CNT_W | Captured count |
| cur_cnt | output | CNT_W | Count latched by a read |
| sum_ovf | output | 1 | Accumulator overflow flag |
| sum_exc | output | 1 | Accumulator exception flag |
| cnt_ovf | output | 1 | Counter overflow flag |
| cnt_exc | output | 1 | Counter exception flag |
| err_irq | output | 1 | Error interrupt |

## Verification
Two functions can act in one cycle: a publish event, and an overflow caused by that cycle's sample. The case is provoked by giving a capture request the same cycle as a sample that overflows an accumulator that already sits at its limit. The result must show two things. The flag reflects only the overflow that was pending before that cycle. The new overflow stays pending, so the next publish raises the flag again. A write-one clear sent in that same cycle also tests that a set takes priority over a clear. A reference model in the bench, written from the requirements, predicts every output after each cycle.

// File: rtl/integ_pkg.sv
package integ_pkg;
    // State held per overflow tracker
    typedef struct packed {
        logic pend;   // overflow seen since last publish or reset
        logic flag;   // visible overflow flag
        logic exc;    // exception flag
    } trk_t;

    localparam int CLR_W       = 4;
    localparam int CLR_SUM_OVF = 0;
    localparam int CLR_SUM_EXC = 1;
    localparam int CLR_CNT_OVF = 2;
    localparam int CLR_CNT_EXC = 3;
endpackage

// File: rtl/integ_datapath.sv
module integ_datapath #(
    parameter int SAMPLE_W = 16,
    parameter int ACC_W    = 32,
    parameter int CNT_W    = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                smp_valid,
    input  logic [SAMPLE_W-1:0] smp_data,
    input  logic                int_rst,
    input  logic                sat_acc,
    input  logic                sat_cnt,
    input  logic                cap_req,
    input  logic                rd_cur,
    output logic [ACC_W-1:0]    acc_o,
    output logic [CNT_W-1:0]    cnt_o,
    output logic [ACC_W-1:0]    fin_val_o,
    output logic [CNT_W-1:0]    fin_cnt_o,
    output logic [CNT_W-1:0]    cur_cnt_o,
    output logic                acc_ovf_o,
    output logic                cnt_ovf_o
);
    localparam int EXT_W = ACC_W + 1 - SAMPLE_W;
    localparam logic [ACC_W-1:0] ACC_MAX = {1'b0, {(ACC_W-1){1'b1}}};
    localparam logic [ACC_W-1:0] ACC_MIN = {1'b1, {(ACC_W-1){1'b0}}};
    localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    typedef struct packed {
        logic [ACC_W-1:0] acc;
        logic [CNT_W-1:0] cnt;
        logic [ACC_W-1:0] fin_val;
        logic [CNT_W-1:0] fin_cnt;
        logic [CNT_W-1:0] cur_cnt;
    } dp_t;

    dp_t        dp_d, dp_q;
    logic [ACC_W:0] sum_wide;
    logic       acc_ovf, cnt_ovf;

    always_comb begin
        sum_wide = {dp_q.acc[ACC_W-1], dp_q.acc}
                 + {{EXT_W{smp_data[SAMPLE_W-1]}}, smp_data};
        acc_ovf  = smp_valid & ~int_rst & (sum_wide[ACC_W] ^ sum_wide[ACC_W-1]);
        cnt_ovf  = smp_valid & ~int_rst & (&dp_q.cnt);

        dp_d = dp_q;
        if (cap_req) begin
            dp_d.fin_val = dp_q.acc;
            dp_d.fin_cnt = dp_q.cnt;
        end
        if (rd_cur) begin
            dp_d.cur_cnt = dp_q.cnt;
        end
        if (int_rst) begin
            dp_d.acc = '0;
            dp_d.cnt = '0;
        end else if (smp_valid) begin
            if (acc_ovf && sat_acc) begin
                dp_d.acc = sum_wide[ACC_W] ? ACC_MIN : ACC_MAX;
            end else begin
                dp_d.acc = sum_wide[ACC_W-1:0];
            end
            if (!(cnt_ovf && sat_cnt)) begin
                dp_d.cnt = dp_q.cnt + CNT_ONE;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) dp_q <= '0;
        else        dp_q <= dp_d;
    end

    assign acc_o     = dp_q.acc;
    assign cnt_o     = dp_q.cnt;
    assign fin_val_o = dp_q.fin_val;
    assign fin_cnt_o = dp_q.fin_cnt;
    assign cur_cnt_o = dp_q.cur_cnt;
    assign acc_ovf_o = acc_ovf;
    assign cnt_ovf_o = cnt_ovf;

    // R2: a saturated accumulator at its top stays there under positive samples
    p_acc_clamp_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (sat_acc && dp_q.acc == ACC_MAX && smp_valid && !smp_data[SAMPLE_W-1] && !int_rst)
        |=> (acc_o == ACC_MAX));
    // R3: a saturated counter at all ones holds
    p_cnt_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (sat_cnt && (&cnt_o) && !int_rst) |=> (&cnt_o));
    // R9: integrator reset zeroes the running values
    p_rst_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        int_rst |=> (acc_o == '0 && cnt_o == '0));
    // R8: a read alone leaves the final registers untouched
    p_read_keeps_final_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_cur && !cap_req) |=> ($stable(fin_val_o) && $stable(fin_cnt_o)));
endmodule

// File: rtl/ovf_tracker.sv
module ovf_tracker
    import integ_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic sat_en,
    input  logic ovf_evt,
    input  logic upd_evt,
    input  logic int_rst,
    input  logic clr_flag,
    input  logic clr_exc,
    output logic flag_o,
    output logic exc_o
);
    trk_t trk_d, trk_q;
    logic publish, dbl_ovf;

    always_comb begin
        publish = upd_evt & trk_q.pend;
        dbl_ovf = ~sat_en & ovf_evt & trk_q.pend & ~upd_evt & ~int_rst;

        trk_d.flag = publish | (trk_q.flag & ~clr_flag);
        trk_d.exc  = (publish & (sat_en | trk_q.flag)) | dbl_ovf
                   | (trk_q.exc & ~clr_exc);
        if (int_rst)      trk_d.pend = 1'b0;
        else if (upd_evt) trk_d.pend = ovf_evt;
        else              trk_d.pend = trk_q.pend | ovf_evt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) trk_q <= '0;
        else        trk_q <= trk_d;
    end

    assign flag_o = trk_q.flag;
    assign exc_o  = trk_q.exc;

    // R4: the flag only rises after a publish event
    p_flag_on_publish_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_o) |-> $past(upd_evt));
    // R5: saturated publish raises flag and exception together
    p_sat_exc_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (sat_en && upd_evt && trk_q.pend) |=> (flag_o && exc_o));
    // R6: non-saturated publish on an already set flag raises the exception
    p_repeat_exc_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!sat_en && upd_evt && trk_q.pend && flag_o) |=> exc_o);
    // R7: second overflow without publish raises exception
    p_double_ovf_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!sat_en && ovf_evt && trk_q.pend && !upd_evt && !int_rst) |=> exc_o);
    // R9: reset drops the pending state
    p_rst_pend_r9: assert property (@(posedge clk) disable iff (!rst_n)
        int_rst |=> !trk_q.pend);
    // R10: a clear without a competing set drops the flag
    p_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_flag && !(upd_evt && trk_q.pend)) |=> !flag_o);
endmodule

// File: rtl/integ_ovf_top.sv
module integ_ovf_top
    import integ_pkg::*;
#(
    parameter int SAMPLE_W = 16,
    parameter int ACC_W    = 32,
    parameter int CNT_W    = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                smp_valid,
    input  logic [SAMPLE_W-1:0] smp_data,
    input  logic                hw_cap,
    input  logic                sw_cap,
    input  logic                rd_cur,
    input  logic                int_rst,
    input  logic                sat_acc_en,
    input  logic                sat_cnt_en,
    input  logic                err_irq_en,
    input  logic [CLR_W-1:0]    flag_clr,
    output logic [ACC_W-1:0]    acc_val,
    output logic [CNT_W-1:0]    cnt_val,
    output logic [ACC_W-1:0]    fin_val,
    output logic [CNT_W-1:0]    fin_cnt,
    output logic [CNT_W-1:0]    cur_cnt,
    output logic                sum_ovf,
    output logic                sum_exc,
    output logic                cnt_ovf,
    output logic                cnt_exc,
    output logic                err_irq
);
    logic cap_req, upd_evt, acc_ovf_evt, cnt_ovf_evt;

    assign cap_req = hw_cap | sw_cap;
    assign upd_evt = cap_req | rd_cur;

    integ_datapath #(.SAMPLE_W(SAMPLE_W), .ACC_W(ACC_W), .CNT_W(CNT_W)) dp_i (
        .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_data(smp_data),
        .int_rst(int_rst), .sat_acc(sat_acc_en), .sat_cnt(sat_cnt_en),
        .cap_req(cap_req), .rd_cur(rd_cur),
        .acc_o(acc_val), .cnt_o(cnt_val), .fin_val_o(fin_val), .fin_cnt_o(fin_cnt),
        .cur_cnt_o(cur_cnt), .acc_ovf_o(acc_ovf_evt), .cnt_ovf_o(cnt_ovf_evt)
    );

    ovf_tracker sum_trk_i (
        .clk(clk), .rst_n(rst_n), .sat_en(sat_acc_en), .ovf_evt(acc_ovf_evt),
        .upd_evt(upd_evt), .int_rst(int_rst),
        .clr_flag(flag_clr[CLR_SUM_OVF]), .clr_exc(flag_clr[CLR_SUM_EXC]),
        .flag_o(sum_ovf), .exc_o(sum_exc)
    );

    ovf_tracker cnt_trk_i (
        .clk(clk), .rst_n(rst_n), .sat_en(sat_cnt_en), .ovf_evt(cnt_ovf_evt),
        .upd_evt(upd_evt), .int_rst(int_rst),
        .clr_flag(flag_clr[CLR_CNT_OVF]), .clr_exc(flag_clr[CLR_CNT_EXC]),
        .flag_o(cnt_ovf), .exc_o(cnt_exc)
    );

    assign err_irq = err_irq_en & (sum_exc | cnt_exc);

    // R11: interrupt never without its enable
    p_irq_gate_r11: assert property (@(posedge clk) disable iff (!rst_n)
        err_irq |-> err_irq_en);
endmodule

// File: tb/integ_ovf_top_tb_top.sv
module integ_ovf_top_tb_top;
    localparam int SW = 16;
    localparam int AW = 20;
    localparam int CW = 4;
    localparam int AMAX = (1 << (AW-1)) - 1;
    localparam int AMIN = -(1 << (AW-1));
    localparam int CMAX = (1 << CW) - 1;

    typedef struct packed {
        logic [7:0]  rep;
        logic        v;
        logic [15:0] d;
        logic        hw, sw, rd, rst, sa, sc, ie;
        logic [3:0]  clr;
    } vec_t;

    function automatic vec_t mk(int rep, bit v, logic [15:0] d, bit hw, bit sw, bit rd,
                                bit rst, bit sa, bit sc, bit ie, logic [3:0] clr);
        vec_t e;
        e.rep = rep[7:0]; e.v = v; e.d = d; e.hw = hw; e.sw = sw; e.rd = rd;
        e.rst = rst; e.sa = sa; e.sc = sc; e.ie = ie; e.clr = clr;
        return e;
    endfunction

    localparam int NV = 17;
    localparam vec_t TBL [NV] = '{
        mk(20, 1, 16'h7FFF, 0, 0, 0, 0, 0, 0, 1, 4'h0), // wrap both paths once
        mk(1,  0, 16'h0000, 0, 0, 1, 0, 0, 0, 1, 4'h0), // read publishes
        mk(20, 1, 16'h7FFF, 0, 0, 0, 0, 0, 0, 1, 4'h0),
        mk(1,  0, 16'h0000, 1, 0, 0, 0, 0, 0, 1, 4'h0), // publish on set flags
        mk(1,  0, 16'h0000, 0, 0, 0, 0, 0, 0, 1, 4'hF), // clear all
        mk(1,  0, 16'h0000, 0, 0, 0, 1, 1, 1, 1, 4'h0), // reset, saturate
        mk(20, 1, 16'h7FFF, 0, 0, 0, 0, 1, 1, 1, 4'h0),
        mk(1,  0, 16'h0000, 0, 1, 0, 0, 1, 1, 1, 4'h0), // sw capture
        mk(40, 1, 16'h8000, 0, 0, 0, 0, 1, 1, 1, 4'h0), // clamp to min
        mk(1,  1, 16'h8000, 1, 0, 0, 0, 1, 1, 1, 4'hF), // capture + overflow + clear
        mk(1,  0, 16'h0000, 0, 0, 1, 0, 1, 1, 1, 4'h0), // re-armed pending
        mk(1,  0, 16'h0000, 0, 0, 0, 1, 0, 0, 0, 4'hF), // reset, wrap mode, irq off
        mk(40, 1, 16'h7FFF, 0, 0, 0, 0, 0, 0, 0, 4'h0), // double overflow
        mk(1,  0, 16'h0000, 0, 0, 0, 0, 0, 0, 1, 4'h0), // irq enabled
        mk(20, 1, 16'h7FFF, 0, 0, 0, 0, 0, 0, 1, 4'hF), // overflow, flags cleared
        mk(1,  1, 16'h0100, 0, 0, 0, 1, 0, 0, 1, 4'h0), // reset drops pending, sample ignored
        mk(1,  0, 16'h0000, 0, 0, 1, 0, 0, 0, 1, 4'h0)  // read: no flag
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic smp_valid = 0, hw_cap = 0, sw_cap = 0, rd_cur = 0, int_rst = 0;
    logic sat_acc_en = 0, sat_cnt_en = 0, err_irq_en = 0;
    logic [SW-1:0] smp_data = '0;
    logic [3:0] flag_clr = '0;
    logic [AW-1:0] acc_val, fin_val;
    logic [CW-1:0] cnt_val, fin_cnt, cur_cnt;
    logic sum_ovf, sum_exc, cnt_ovf, cnt_exc, err_irq;

    always #10 clk = ~clk; // 50 MHz

    integ_ovf_top #(.SAMPLE_W(SW), .ACC_W(AW), .CNT_W(CW)) dut_i (
        .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_data(smp_data),
        .hw_cap(hw_cap), .sw_cap(sw_cap), .rd_cur(rd_cur), .int_rst(int_rst),
        .sat_acc_en(sat_acc_en), .sat_cnt_en(sat_cnt_en), .err_irq_en(err_irq_en),
        .flag_clr(flag_clr), .acc_val(acc_val), .cnt_val(cnt_val), .fin_val(fin_val),
        .fin_cnt(fin_cnt), .cur_cnt(cur_cnt), .sum_ovf(sum_ovf), .sum_exc(sum_exc),
        .cnt_ovf(cnt_ovf), .cnt_exc(cnt_exc), .err_irq(err_irq)
    );

    int checks = 0, fails = 0;
    bit done = 0;

    // Reference model state
    int m_acc, m_cnt, m_fv, m_fc, m_cc;
    bit m_pa, m_pc, m_so, m_se, m_co, m_ce;

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic model_step(vec_t e);
        int  sum, d;
        bit  upd, ea, ec, pub_a, pub_c, sa_set, ca_set, se_set, ce_set;
        d   = $signed(e.d);
        upd = e.hw | e.sw | e.rd;
        sum = m_acc + d;
        ea  = e.v && !e.rst && (sum > AMAX || sum < AMIN);
        ec  = e.v && !e.rst && (m_cnt == CMAX);
        pub_a = upd && m_pa;
        pub_c = upd && m_pc;
        sa_set = pub_a;
        ca_set = pub_c;
        se_set = (pub_a && (e.sa || m_so)) || (!e.sa && ea && m_pa && !upd);
        ce_set = (pub_c && (e.sc || m_co)) || (!e.sc && ec && m_pc && !upd);
        if (e.hw || e.sw) begin m_fv = m_acc; m_fc = m_cnt; end
        if (e.rd) m_cc = m_cnt;
        if (e.rst) begin
            m_acc = 0; m_cnt = 0; m_pa = 0; m_pc = 0;
        end else begin
            if (e.v) begin
                if (ea && e.sa)      m_acc = (sum > AMAX) ? AMAX : AMIN;
                else if (sum > AMAX) m_acc = sum - (1 << AW);
                else if (sum < AMIN) m_acc = sum + (1 << AW);
                else                 m_acc = sum;
                if (!(ec && e.sc)) m_cnt = (m_cnt + 1) & CMAX;
            end
            m_pa = upd ? ea : (m_pa | ea);
            m_pc = upd ? ec : (m_pc | ec);
        end
        m_so = sa_set | (m_so & !e.clr[0]);
        m_se = se_set | (m_se & !e.clr[1]);
        m_co = ca_set | (m_co & !e.clr[2]);
        m_ce = ce_set | (m_ce & !e.clr[3]);
    endtask

    task automatic check_all(bit ie);
        chk("R1/R2 acc_val", $signed(acc_val), m_acc);
        chk("R1/R3 cnt_val", int'(cnt_val), m_cnt);
        chk("R8 fin_val", $signed(fin_val), m_fv);
        chk("R8 fin_cnt", int'(fin_cnt), m_fc);
        chk("R8 cur_cnt", int'(cur_cnt), m_cc);
        chk("R4/R9/R10 sum_ovf", int'(sum_ovf), int'(m_so));
        chk("R4/R9/R10 cnt_ovf", int'(cnt_ovf), int'(m_co));
        chk("R5/R6/R7 sum_exc", int'(sum_exc), int'(m_se));
        chk("R5/R6/R7 cnt_exc", int'(cnt_exc), int'(m_ce));
        chk("R11 err_irq", int'(err_irq), int'(ie && (m_se || m_ce)));
    endtask

    task automatic apply(vec_t e);
        smp_valid = e.v; smp_data = e.d; hw_cap = e.hw; sw_cap = e.sw; rd_cur = e.rd;
        int_rst = e.rst; sat_acc_en = e.sa; sat_cnt_en = e.sc; err_irq_en = e.ie;
        flag_clr = e.clr;
        @(posedge clk);
        model_step(e);
        @(negedge clk);
        check_all(e.ie);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        m_acc = 0; m_cnt = 0; m_fv = 0; m_fc = 0; m_cc = 0;
        m_pa = 0; m_pc = 0; m_so = 0; m_se = 0; m_co = 0; m_ce = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R12: reset state
        chk("R12 acc_val", int'(acc_val), 0);
        chk("R12 cnt_val", int'(cnt_val), 0);
        chk("R12 fin_val", int'(fin_val), 0);
        chk("R12 flags", int'({sum_ovf, sum_exc, cnt_ovf, cnt_exc, err_irq}), 0);

        for (int i = 0; i < NV; i++) begin
            for (int r = 0; r < int'(TBL[i].rep); r++) apply(TBL[i]);
        end

        // Directed: saturation limits with literal values (R2, R3)
        apply(mk(1, 0, 16'h0000, 0, 0, 0, 1, 1, 1, 0, 4'hF));
        for (int r = 0; r < 20; r++) apply(mk(1, 1, 16'h7FFF, 0, 0, 0, 0, 1, 1, 0, 4'h0));
        chk("R2 clamp max", int'(acc_val), 20'h7FFFF);
        chk("R3 hold all ones", int'(cnt_val), 4'hF);
        // Directed: overflow alone does not raise the visible flag (R4)
        chk("R4 no flag without publish", int'(sum_ovf), 0);
        // Directed: wrap mode single step past the top (R2, R3)
        apply(mk(1, 0, 16'h0000, 0, 0, 0, 1, 0, 0, 0, 4'hF));
        for (int r = 0; r < 16; r++) apply(mk(1, 1, 16'h7FFF, 0, 0, 0, 0, 0, 0, 0, 4'h0));
        chk("R3 wrap to zero", int'(cnt_val), 0);
        apply(mk(1, 1, 16'h7FFF, 0, 0, 0, 0, 0, 0, 0, 4'h0));
        chk("R2 wrap negative", $signed(acc_val), 17 * 32767 - (1 << AW));

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule